// File: doc/BRIEF.md
# Serial Command Decoder for a Memory Bridge

This block sits between a host microcontroller and a memory bridge. The host talks to it over a four-wire serial link. The host clock idles low, bits are sampled on the rising edge, and the most significant bit comes first. The block oversamples that link with its own system clock and cuts it into bytes. Each assertion of chip select starts a new command. The first byte is an opcode. The bytes after it are parameters, stream data, or dummy bytes that carry a reply back to the host.

The decoder holds several registers: a 24-bit address pointer, an input address mask, a save-RAM address mask, a 4-bit mapper mode, and a one-bit memory-unit select. It issues single-cycle read and write requests to a memory port, with optional address auto-increment. It returns fetched data, a liveness token or a status byte on the serial output. It also emits a one-cycle start strobe for a DMA engine that lives outside the block.

Top module: `spi_mem_bridge_ctl`

## Requirements
- R1: Opcode 0x00 followed by three bytes, most significant first, loads the address pointer (`mem_addr`) once the third byte is complete.
- R2: Opcode 0x01 plus three bytes loads `in_mask`, and opcode 0x02 plus three bytes loads `save_mask`, in the same byte order as R1.
- R3: Any opcode 0x30–0x3F copies its low nibble into `mapper_mode`. Later bytes in the same chip-select frame are ignored.
- R4: After opcode 0x40, the completion of the next (dummy) byte pulses `dma_start` for exactly one clock. If chip select rises before that byte completes, there is no pulse.
- R5: After opcode 0x80 or 0x81, each following byte clocked out carries the memory data at the pointer. The fetch for the first byte is made when the opcode completes, and a further fetch is made after each byte. With 0x80 the pointer steps by one after every fetch, so n bytes leave it at start+n+1. With 0x81 it does not move.
- R6: After opcode 0x90 or 0x91, every further byte is written with a one-cycle `mem_wr_req` at the pointer. With 0x90 the pointer steps by one after each write. With 0x91 it stays put.
- R7: Opcode 0xE0 sets `mem_unit` to 0 (ROM), and 0xE1 sets it to 1 (save RAM).
- R8: After opcode 0xF0, the next byte clocked out is 0xA5.
- R9: After opcode 0xF1, one dummy byte follows. Every byte after that returns a status byte whose bit 7 equals `dma_busy` and whose bits 6..0 are zero.
- R10: Raising chip select abandons a partly received command, leaving every register unchanged. The next frame starts again at an opcode. While chip select is high, `spi_miso` is 0, and the first byte of a frame clocks out 0x00.
- R11: Opcodes outside R1–R9 (for example 0x55, 0x41, 0x03 and 0xE5) change nothing, and the rest of their frame is ignored.
- R12: After reset the pointer and both masks are 0, `mapper_mode` is 7, `mem_unit` is 0, and no request or strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Host serial clock |
| spi_cs_n | input | 1 | Host chip select, active low |
| spi_mosi | input | 1 | Host-to-block serial data |
| spi_miso | output | 1 | Block-to-host serial data |
| mem_rd_req | output | 1 | One-cycle memory read request |
| mem_wr_req | output | 1 | One-cycle memory write request |
| mem_addr | output | 24 | Address pointer presented to memory |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| mem_unit | output | 1 | Target memory unit: 0 ROM, 1 save RAM |
| in_mask | output | 24 | Input address mask |
| save_mask | output | 24 | Save-RAM address mask |
| mapper_mode | output | 4 | Mapper mode |
| dma_start | output | 1 | One-cycle DMA start strobe |
| dma_busy | input | 1 | DMA engine busy flag, reported in status |

## Verification
Incrementing and non-incrementing write streams are followed by incrementing and fixed reads over overlapping addresses. This shows whether a non-incrementing write really left its neighbours untouched, and whether the prefetch order is right. Frames that carry extra bytes after a one-byte command, frames cut short by chip select, and undefined opcodes close to valid ones (0x41, 0x03, 0xE5) separate a correct ignore path from a decoder that matches too loosely. Status frames run with the busy flag low and then high, and the token frame checks the reply byte against the zero byte that opens every frame.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_PARAM,
        ST_RD,
        ST_WR,
        ST_DMA,
        ST_STDUM,
        ST_STAT,
        ST_IGN
    } dstate_e;

    typedef enum logic [1:0] {
        SRC_ZERO,
        SRC_MEM,
        SRC_TOKEN,
        SRC_STATUS
    } txsrc_e;

    typedef enum logic [1:0] {
        PT_ADDR,
        PT_IMASK,
        PT_SMASK
    } ptgt_e;

    localparam logic [7:0] ALIVE_TOKEN = 8'hA5;

    localparam logic [3:0] GRP_PARAM  = 4'h0;
    localparam logic [3:0] GRP_MAPPER = 4'h3;
    localparam logic [3:0] GRP_DMA    = 4'h4;
    localparam logic [3:0] GRP_READ   = 4'h8;
    localparam logic [3:0] GRP_WRITE  = 4'h9;
    localparam logic [3:0] GRP_UNIT   = 4'hE;
    localparam logic [3:0] GRP_QUERY  = 4'hF;

endpackage

// File: rtl/spi_byte_port.sv
module spi_byte_port #(
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sck,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    input  logic       tx_load,
    input  logic [7:0] tx_data,
    output logic       sel,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       spi_miso
);

    logic [SYNC-1:0] sck_sy, cs_sy, mosi_sy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_sy  <= '0;
            cs_sy   <= '1;
            mosi_sy <= '0;
        end else begin
            sck_sy  <= {sck_sy[SYNC-2:0], spi_sck};
            cs_sy   <= {cs_sy[SYNC-2:0], spi_cs_n};
            mosi_sy <= {mosi_sy[SYNC-2:0], spi_mosi};
        end
    end

    logic sck_now, mosi_now, active;
    assign sck_now  = sck_sy[SYNC-1];
    assign mosi_now = mosi_sy[SYNC-1];
    assign active   = !cs_sy[SYNC-1];

    typedef struct packed {
        logic       sck_prev;
        logic [2:0] cnt;
        logic [7:0] rx_sh;
        logic [7:0] tx_sh;
        logic       valid;
        logic [7:0] byte_out;
    } port_t;

    port_t q, d;
    logic  rise, fall;

    assign rise = sck_now && !q.sck_prev;
    assign fall = !sck_now && q.sck_prev;

    always_comb begin
        d          = q;
        d.valid    = 1'b0;
        d.sck_prev = sck_now;
        if (!active) begin
            d.cnt   = '0;
            d.rx_sh = '0;
            d.tx_sh = '0;
        end else begin
            if (rise) begin
                d.rx_sh = {q.rx_sh[6:0], mosi_now};
                d.cnt   = q.cnt + 3'd1;
                if (q.cnt == 3'd7) begin
                    d.valid    = 1'b1;
                    d.byte_out = {q.rx_sh[6:0], mosi_now};
                end
            end
            if (fall && q.cnt != 3'd0) begin
                d.tx_sh = {q.tx_sh[6:0], 1'b0};
            end
            if (tx_load) begin
                d.tx_sh = tx_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sel      = active;
    assign rx_valid = q.valid;
    assign rx_byte  = q.byte_out;
    assign spi_miso = q.tx_sh[7];

endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
    import bridge_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter logic [3:0]  MAP_RESET = 4'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic [7:0]        mem_rdata,
    input  logic              dma_busy,
    output logic              tx_load,
    output logic [7:0]        tx_data,
    output logic              mem_rd_req,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [ADDR_W-1:0] in_mask,
    output logic [ADDR_W-1:0] save_mask,
    output logic [3:0]        mapper_mode,
    output logic              mem_unit,
    output logic              dma_start
);

    localparam int ABYTES = ADDR_W / 8;
    localparam int PCW    = (ABYTES > 1) ? $clog2(ABYTES) : 1;
    localparam logic [PCW-1:0] PLAST = PCW'(ABYTES - 1);

    typedef struct packed {
        dstate_e           st;
        ptgt_e             ptgt;
        logic [PCW-1:0]    pcnt;
        logic [ADDR_W-9:0] psh;
        logic              incr;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] imask;
        logic [ADDR_W-1:0] smask;
        logic [3:0]        mapper;
        logic              unit;
        logic [7:0]        wdata;
        logic              dma;
        logic              p1_rd;
        logic              p1_wr;
        logic              p1_inc;
        logic              p1_load;
        txsrc_e            p1_src;
        logic              p2_load;
        txsrc_e            p2_src;
    } dec_t;

    dec_t q, d;

    logic [3:0]        hi, lo;
    logic [ADDR_W-1:0] word;
    assign hi   = rx_byte[7:4];
    assign lo   = rx_byte[3:0];
    assign word = {q.psh, rx_byte};

    always_comb begin
        d         = q;
        d.dma     = 1'b0;
        d.p1_rd   = 1'b0;
        d.p1_wr   = 1'b0;
        d.p1_inc  = 1'b0;
        d.p1_load = 1'b0;
        d.p1_src  = SRC_ZERO;
        d.p2_load = q.p1_load;
        d.p2_src  = q.p1_src;
        if (q.p1_inc) begin
            d.addr = q.addr + 1'b1;
        end
        if (!sel) begin
            d.st   = ST_OPC;
            d.pcnt = '0;
        end else if (rx_valid) begin
            d.p1_load = 1'b1;
            unique case (q.st)
                ST_OPC: begin
                    d.st = ST_IGN;
                    unique case (hi)
                        GRP_PARAM: begin
                            if (lo <= 4'd2) begin
                                d.st   = ST_PARAM;
                                d.pcnt = '0;
                                d.ptgt = (lo == 4'd0) ? PT_ADDR :
                                         (lo == 4'd1) ? PT_IMASK : PT_SMASK;
                            end
                        end
                        GRP_MAPPER: d.mapper = lo;
                        GRP_DMA: begin
                            if (lo == 4'd0) d.st = ST_DMA;
                        end
                        GRP_READ: begin
                            if (lo <= 4'd1) begin
                                d.st     = ST_RD;
                                d.incr   = (lo == 4'd0);
                                d.p1_rd  = 1'b1;
                                d.p1_inc = (lo == 4'd0);
                                d.p1_src = SRC_MEM;
                            end
                        end
                        GRP_WRITE: begin
                            if (lo <= 4'd1) begin
                                d.st   = ST_WR;
                                d.incr = (lo == 4'd0);
                            end
                        end
                        GRP_UNIT: begin
                            if (lo <= 4'd1) d.unit = lo[0];
                        end
                        GRP_QUERY: begin
                            if (lo == 4'd0) d.p1_src = SRC_TOKEN;
                            else if (lo == 4'd1) d.st = ST_STDUM;
                        end
                        default: d.st = ST_IGN;
                    endcase
                end
                ST_PARAM: begin
                    d.psh = word[ADDR_W-9:0];
                    if (q.pcnt == PLAST) begin
                        d.st = ST_IGN;
                        unique case (q.ptgt)
                            PT_ADDR:  d.addr  = word;
                            PT_IMASK: d.imask = word;
                            default:  d.smask = word;
                        endcase
                    end else begin
                        d.pcnt = q.pcnt + 1'b1;
                    end
                end
                ST_RD: begin
                    d.p1_rd  = 1'b1;
                    d.p1_inc = q.incr;
                    d.p1_src = SRC_MEM;
                end
                ST_WR: begin
                    d.p1_wr  = 1'b1;
                    d.p1_inc = q.incr;
                    d.wdata  = rx_byte;
                end
                ST_DMA: begin
                    d.dma = 1'b1;
                    d.st  = ST_IGN;
                end
                ST_STDUM: begin
                    d.st     = ST_STAT;
                    d.p1_src = SRC_STATUS;
                end
                ST_STAT:  d.p1_src = SRC_STATUS;
                default:  d.st = ST_IGN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_OPC;
            q.mapper <= MAP_RESET;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.p2_src)
            SRC_MEM:    tx_data = mem_rdata;
            SRC_TOKEN:  tx_data = ALIVE_TOKEN;
            SRC_STATUS: tx_data = {dma_busy, 7'b0};
            default:    tx_data = 8'h00;
        endcase
    end

    assign tx_load     = q.p2_load;
    assign mem_rd_req  = q.p1_rd;
    assign mem_wr_req  = q.p1_wr;
    assign mem_addr    = q.addr;
    assign mem_wdata   = q.wdata;
    assign in_mask     = q.imask;
    assign save_mask   = q.smask;
    assign mapper_mode = q.mapper;
    assign mem_unit    = q.unit;
    assign dma_start   = q.dma;

endmodule

// File: rtl/spi_mem_bridge_ctl.sv
module spi_mem_bridge_ctl #(
    parameter int         ADDR_W    = 24,
    parameter int         SYNC      = 2,
    parameter logic [3:0] MAP_RESET = 4'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              mem_rd_req,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              mem_unit,
    output logic [ADDR_W-1:0] in_mask,
    output logic [ADDR_W-1:0] save_mask,
    output logic [3:0]        mapper_mode,
    output logic              dma_start,
    input  logic              dma_busy
);

    logic       sel, rx_valid, tx_load;
    logic [7:0] rx_byte, tx_data;

    spi_byte_port #(.SYNC(SYNC)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sck  (spi_sck),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi),
        .tx_load  (tx_load),
        .tx_data  (tx_data),
        .sel      (sel),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .spi_miso (spi_miso)
    );

    cmd_decoder #(.ADDR_W(ADDR_W), .MAP_RESET(MAP_RESET)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .mem_rdata   (mem_rdata),
        .dma_busy    (dma_busy),
        .tx_load     (tx_load),
        .tx_data     (tx_data),
        .mem_rd_req  (mem_rd_req),
        .mem_wr_req  (mem_wr_req),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .in_mask     (in_mask),
        .save_mask   (save_mask),
        .mapper_mode (mapper_mode),
        .mem_unit    (mem_unit),
        .dma_start   (dma_start)
    );

endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_miso,
    input logic              mem_rd_req,
    input logic              mem_wr_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              dma_start
);

    // R5, R6: a read and a write never share a cycle
    a_r5_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));

    // R4: the DMA strobe lasts one cycle
    a_r4_dma_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |=> !dma_start);

    // R6: a write request lasts one cycle
    a_r6_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |=> !mem_wr_req);

    // R6: the pointer has settled when a write is issued
    a_r6_wr_addr_settled: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> $stable(mem_addr));

    // R10: output low once chip select has been high for a while
    a_r10_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) &&
         $past(spi_cs_n, 3) && $past(spi_cs_n, 4)) |-> !spi_miso);

endmodule

bind spi_mem_bridge_ctl bridge_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_cs_n   (spi_cs_n),
    .spi_miso   (spi_miso),
    .mem_rd_req (mem_rd_req),
    .mem_wr_req (mem_wr_req),
    .mem_addr   (mem_addr),
    .dma_start  (dma_start)
);

// File: tb/tb_spi_mem_bridge_ctl.sv
module tb_spi_mem_bridge_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic        spi_miso, mem_rd_req, mem_wr_req, mem_unit, dma_start;
    logic        dma_busy = 1'b0;
    logic [23:0] mem_addr, in_mask, save_mask;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [3:0]  mapper_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_mem_bridge_ctl dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .mem_rd_req(mem_rd_req),
        .mem_wr_req(mem_wr_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_unit(mem_unit), .in_mask(in_mask),
        .save_mask(save_mask), .mapper_mode(mapper_mode),
        .dma_start(dma_start), .dma_busy(dma_busy)
    );

    // environment memory: one-cycle read latency
    logic [7:0] bmem [0:255];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bmem[i] <= 8'(i) ^ 8'h5A;
            mem_rdata <= 8'h00;
        end else begin
            if (mem_wr_req) bmem[mem_addr[7:0]] <= mem_wdata;
            if (mem_rd_req) mem_rdata <= bmem[mem_addr[7:0]];
        end
    end

    int n_cmp = 0, n_bad = 0, dma_cnt = 0;
    bit done = 0, cmp_en = 0;

    // reference model of the register state
    logic [23:0] e_addr = 0, e_imask = 0, e_smask = 0;
    logic [3:0]  e_map = 4'd7;
    logic        e_unit = 0;
    int          e_dma = 0;

    always @(posedge clk) if (rst_n && dma_start) dma_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk("R1 pointer", {8'h0, mem_addr}, {8'h0, e_addr});
            chk("R2 masks", {8'h0, in_mask ^ save_mask}, {8'h0, e_imask ^ e_smask});
            chk("R3 mapper", {28'h0, mapper_mode}, {28'h0, e_map});
            chk("R7 unit", {31'h0, mem_unit}, {31'h0, e_unit});
            chk("R10 idle outputs", {29'h0, spi_miso, mem_wr_req, dma_start}, 32'h0);
        end
    end

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic cs_on();
        cmp_en = 0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic cs_off();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (12) @(negedge clk);
        chk("R4 dma count", dma_cnt, e_dma);
        cmp_en = 1;
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] r;
        xfer(b, r);
    endtask

    task automatic frame4(input logic [7:0] a, input logic [23:0] v);
        cs_on(); send(a); send(v[23:16]); send(v[15:8]); send(v[7:0]); cs_off();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R12 reset values
        chk("R12 pointer", {8'h0, mem_addr}, 0);
        chk("R12 mapper", {28'h0, mapper_mode}, 7);
        chk("R12 requests", {30'h0, mem_rd_req, mem_wr_req}, 0);
        cmp_en = 1;

        // R1 pointer load
        frame4(8'h00, 24'h000010); e_addr = 24'h10;
        chk("R1 load", {8'h0, mem_addr}, 32'h10);

        // R6 incrementing write
        cs_on(); send(8'h90); send(8'h11); send(8'h22); send(8'h33); send(8'h44);
        e_addr = 24'h14; cs_off();

        // R6 fixed write: only the last byte stays at 0x20
        frame4(8'h00, 24'h000020); e_addr = 24'h20;
        cs_on(); send(8'h91); send(8'hAA); send(8'hBB); send(8'hCC); cs_off();

        // R5 incrementing read over the incrementing write
        frame4(8'h00, 24'h000010); e_addr = 24'h10;
        cs_on(); send(8'h80);
        xfer(8'h00, r); chk("R5 rd0", r, 8'h11);
        xfer(8'h00, r); chk("R5 rd1", r, 8'h22);
        xfer(8'h00, r); chk("R5 rd2", r, 8'h33);
        xfer(8'h00, r); chk("R5 rd3", r, 8'h44);
        e_addr = 24'h15; cs_off();

        // R5 read across fixed-write region (R6 neighbours untouched)
        frame4(8'h00, 24'h00001F); e_addr = 24'h1F;
        cs_on(); send(8'h80);
        xfer(8'h00, r); chk("R6 neighbour below", r, 8'h1F ^ 8'h5A);
        xfer(8'h00, r); chk("R6 fixed target", r, 8'hCC);
        xfer(8'h00, r); chk("R6 neighbour above", r, 8'h21 ^ 8'h5A);
        e_addr = 24'h23; cs_off();

        // R5 fixed read
        frame4(8'h00, 24'h000020); e_addr = 24'h20;
        cs_on(); send(8'h81);
        for (int k = 0; k < 3; k++) begin
            xfer(8'h00, r); chk("R5 fixed read", r, 8'hCC);
        end
        cs_off();

        // R2 masks
        frame4(8'h01, 24'h123456); e_imask = 24'h123456;
        frame4(8'h02, 24'hABCDEF); e_smask = 24'hABCDEF;
        chk("R2 in_mask", {8'h0, in_mask}, 32'h123456);
        chk("R2 save_mask", {8'h0, save_mask}, 32'hABCDEF);

        // R3 mapper, trailing byte ignored
        cs_on(); send(8'h36); send(8'h32); cs_off(); e_map = 4'd6;
        chk("R3 mapper 6", {28'h0, mapper_mode}, 6);
        cs_on(); send(8'h31); cs_off(); e_map = 4'd1;

        // R7 unit select
        cs_on(); send(8'hE1); cs_off(); e_unit = 1;
        chk("R7 unit 1", {31'h0, mem_unit}, 1);
        cs_on(); send(8'hE0); cs_off(); e_unit = 0;

        // R8 token, R10 first byte is zero
        cs_on(); xfer(8'hF0, r); chk("R10 first byte", r, 8'h00);
        xfer(8'h00, r); chk("R8 token", r, 8'hA5); cs_off();

        // R9 status
        dma_busy = 1'b0;
        cs_on(); send(8'hF1); send(8'h00);
        xfer(8'h00, r); chk("R9 idle status", r, 8'h00); cs_off();
        dma_busy = 1'b1;
        cs_on(); send(8'hF1); xfer(8'h00, r); chk("R9 dummy", r, 8'h00);
        xfer(8'h00, r); chk("R9 busy status", r, 8'h80);
        xfer(8'h00, r); chk("R9 busy repeat", r, 8'h80); cs_off();
        dma_busy = 1'b0;

        // R4 DMA strobe
        cs_on(); send(8'h40); send(8'h00); e_dma++; cs_off();
        cs_on(); send(8'h40); cs_off();
        cs_on(); send(8'h40); send(8'h00); send(8'h00); e_dma++; cs_off();

        // R10 abort a partial pointer load, then a fresh frame
        cs_on(); send(8'h00); send(8'h12); send(8'h34); cs_off();
        chk("R10 abort keeps pointer", {8'h0, mem_addr}, 32'h20);
        frame4(8'h00, 24'h000007); e_addr = 24'h7;

        // R11 unknown opcodes
        cs_on(); send(8'h55); send(8'h36); send(8'hE1); cs_off();
        cs_on(); send(8'h41); send(8'h00); cs_off();
        cs_on(); send(8'h03); send(8'h99); send(8'h99); send(8'h99); cs_off();
        cs_on(); send(8'hE5); cs_off();
        chk("R11 mapper kept", {28'h0, mapper_mode}, 1);
        chk("R11 unit kept", {31'h0, mem_unit}, 0);
        chk("R11 pointer kept", {8'h0, mem_addr}, 32'h7);

        repeat (10) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule